// File: doc/BRIEF.md
# Two-Input Ones Counter Modulo Four

This block watches two single-bit data lines and keeps a running tally of every 1 it sees on them. The tally advances at each rising clock edge by the number of lines that are high in that cycle: zero, one or two. Only the tally modulo four is kept. The flag output is high whenever the tally is a whole multiple of four, for example 0, 4 or 8. The flag is a Moore output, so it is decoded from the registered state alone. Whatever the inputs do between edges, the flag changes only at a clock edge.

The state machine has four named states: `ST_ZERO` (tally mod 4 = 0, flag high), `ST_ONE`, `ST_TWO` and `ST_THREE` (flag low). Each state takes one of three transitions:
- **hold**: both lines low, the state stays where it is.
- **step**: exactly one line high, the state moves to the next state in the ring ZERO→ONE→TWO→THREE→ZERO.
- **leap**: both lines high, the state skips ahead two places: ZERO→TWO, ONE→THREE, TWO→ZERO, THREE→ONE.

A synchronous active-high reset overrides all three transitions and forces `ST_ZERO`.

The block can be built in two ways, selected by a parameter, and both give the same output in every cycle. The behavioural build uses an enumerated state register and a case-based next-state process. The structural build is two D flip-flops joined by AND, XOR and NOR gates: a two-bit adder with a gated reset.

Top module: `onescnt_mod4`

## Requirements
- R1: When `rst` is high at a rising edge, the state becomes `ST_ZERO` whatever `in_a` and `in_b` are, so `zero_flag` is 1 in the cycle after that edge.
- R2: A rising edge with `in_a`=0 and `in_b`=0 leaves the state unchanged (hold).
- R3: A rising edge with exactly one of `in_a`, `in_b` equal to 1 advances the state by one modulo four (step).
- R4: A rising edge with `in_a`=1 and `in_b`=1 advances the state by two modulo four (leap). Successive leap cycles each add two.
- R5: `zero_flag` is 1 exactly when the total number of 1s sampled on both inputs since the last reset is a multiple of four.
- R6: When `zero_flag` is 1, a rising edge with any input high makes `zero_flag` 0.
- R7: A leap from `ST_THREE` goes to `ST_ONE`, so `zero_flag` stays 0. A leap from `ST_TWO` goes to `ST_ZERO`, so `zero_flag` becomes 1.
- R8: `zero_flag` depends only on the registered state. Changing `in_a` or `in_b` between clock edges does not change it.
- R9: The structural build (`USE_GATES`=1) and the behavioural build (`USE_GATES`=0) produce identical `zero_flag` in every cycle for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First data line; each 1 adds one to the tally |
| in_b | input | 1 | Second data line; each 1 adds one to the tally |
| zero_flag | output | 1 | High when the tally modulo four is zero |

## Verification
The bench instantiates the block twice, once with `USE_GATES`=0 and once with `USE_GATES`=1, and drives both from the same inputs. This makes R9 a comparison in every cycle rather than two separate runs.

Because the state space is only four states by four input pairs, the bench sweeps all sixteen combinations. For each one it recovers the resulting state from the flag alone, by counting how many step cycles it takes to bring `zero_flag` back to 1.

A long pseudo-random run, with stretches of consecutive leap cycles, is checked against a running count kept in the bench.

// File: rtl/onescnt_pkg.sv
`timescale 1ns/1ps
package onescnt_pkg;
    localparam int STATE_W = 2;
    localparam int MODULUS = 1 << STATE_W;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO  = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2,
        ST_THREE = 2'd3
    } cnt_state_e;
endpackage

// File: rtl/onescnt_dff.sv
`timescale 1ns/1ps
module onescnt_dff (
    input  logic clk,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/onescnt_gate.sv
`timescale 1ns/1ps
module onescnt_gate
    import onescnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    output logic flag
);
    logic [STATE_W-1:0] st;
    logic [STATE_W-1:0] nxt;
    logic [STATE_W-1:0] d;
    logic               inc_lo;
    logic               inc_hi;
    logic               carry;

    // increment as a two-bit value: {a&b, a^b}
    assign inc_lo = in_a ^ in_b;
    assign inc_hi = in_a & in_b;

    // two-bit ripple adder, carry out of bit 1 dropped (mod four)
    assign carry  = st[0] & inc_lo;
    assign nxt[0] = st[0] ^ inc_lo;
    assign nxt[1] = st[1] ^ inc_hi ^ carry;

    generate
        for (genvar i = 0; i < STATE_W; i++) begin : g_bit
            assign d[i] = nxt[i] & ~rst;
            onescnt_dff u_ff (
                .clk (clk),
                .d   (d[i]),
                .q   (st[i])
            );
        end
    endgenerate

    assign flag = ~(st[1] | st[0]);

    // R3: a step cycle moves the state one place around the ring
    a_r3_step_adds_one: assert property (@(posedge clk) disable iff (rst)
        (in_a ^ in_b) |=> st == STATE_W'($past(st) + 2'd1));

    // R2: a hold cycle keeps the state
    a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        (!in_a && !in_b) |=> st == $past(st));
endmodule

// File: rtl/onescnt_beh.sv
`timescale 1ns/1ps
module onescnt_beh
    import onescnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    output logic flag
);
    cnt_state_e         st_q;
    cnt_state_e         st_d;
    logic               one_up;
    logic               two_up;
    logic [STATE_W-1:0] st_bits;

    assign one_up  = in_a ^ in_b;
    assign two_up  = in_a & in_b;
    assign st_bits = st_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_ZERO;
        else     st_q <= st_d;
    end

    // next-state: hold, step or leap from each state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ZERO:  st_d = two_up ? ST_TWO   : (one_up ? ST_ONE   : ST_ZERO);
            ST_ONE:   st_d = two_up ? ST_THREE : (one_up ? ST_TWO   : ST_ONE);
            ST_TWO:   st_d = two_up ? ST_ZERO  : (one_up ? ST_THREE : ST_TWO);
            ST_THREE: st_d = two_up ? ST_ONE   : (one_up ? ST_ZERO  : ST_THREE);
            default:  st_d = ST_ZERO;
        endcase
    end

    // Moore output
    always_comb begin
        flag = (st_q == ST_ZERO);
    end

    // R4: a leap cycle adds two
    a_r4_leap_adds_two: assert property (@(posedge clk) disable iff (rst)
        (in_a && in_b) |=> st_bits == STATE_W'($past(st_bits) + 2'd2));

    // R7: leap from THREE wraps to ONE
    a_r7_three_leaps_to_one: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_THREE && in_a && in_b) |=> st_q == ST_ONE);
endmodule

// File: rtl/onescnt_mod4.sv
`timescale 1ns/1ps
module onescnt_mod4 #(
    parameter bit USE_GATES = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    output logic zero_flag
);
    generate
        if (USE_GATES) begin : g_struct
            onescnt_gate u_core (
                .clk  (clk),
                .rst  (rst),
                .in_a (in_a),
                .in_b (in_b),
                .flag (zero_flag)
            );
        end else begin : g_behav
            onescnt_beh u_core (
                .clk  (clk),
                .rst  (rst),
                .in_a (in_a),
                .in_b (in_b),
                .flag (zero_flag)
            );
        end
    endgenerate

    // R1: reset at an edge leaves the flag high
    a_r1_reset_to_zero: assert property (@(posedge clk)
        rst |=> zero_flag);

    // R6: any 1 while the flag is high clears it
    a_r6_leave_zero: assert property (@(posedge clk) disable iff (rst)
        (zero_flag && (in_a || in_b)) |=> !zero_flag);
endmodule

// File: tb/tb_onescnt_mod4.sv
`timescale 1ns/1ps
module tb_onescnt_mod4;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic zf;
    logic zf_g;
    int   n_chk = 0;
    int   n_err = 0;
    int   model = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    onescnt_mod4 #(.USE_GATES(1'b0)) dut (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .zero_flag(zf));
    onescnt_mod4 #(.USE_GATES(1'b1)) dut_g (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .zero_flag(zf_g));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive inputs at the falling edge, sample 1 ns after the rising edge
    task automatic step(input logic a, input logic b);
        @(negedge clk);
        in_a = a;
        in_b = b;
        @(posedge clk);
        #1;
        if (!rst) model = (model + int'(a) + int'(b)) % 4;
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst  = 1'b1;
        in_a = a;
        in_b = b;
        @(posedge clk);
        #1;
        model = 0;
        @(negedge clk);
        rst  = 1'b0;
        in_a = 1'b0;
        in_b = 1'b0;
    endtask

    // count step cycles until the flag returns high; gives state = (4-k)%4
    task automatic probe(output int st_a, output int st_g);
        int ka = -1;
        int kg = -1;
        for (int k = 0; k < 4; k++) begin
            if (ka < 0 && zf === 1'b1)   ka = k;
            if (kg < 0 && zf_g === 1'b1) kg = k;
            if (ka >= 0 && kg >= 0) break;
            step(1'b1, 1'b0);
        end
        st_a = (ka < 0) ? -1 : (4 - ka) % 4;
        st_g = (kg < 0) ? -1 : (4 - kg) % 4;
    endtask

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog expired actual=running expected=done");
        n_err++;
        n_chk++;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int sa, sg, ex;
        string tag;
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset behav", zf, 1);
        check("R1 reset gates", zf_g, 1);
        @(negedge clk);
        rst = 1'b0;

        // R6: leaving zero on one input and on both
        step(1'b0, 1'b1);
        check("R6 single clears flag", zf, 0);
        do_reset(1'b0, 1'b0);
        step(1'b1, 1'b1);
        check("R6 double clears flag", zf_g, 0);

        // R7: THREE --leap--> ONE ; TWO --leap--> ZERO
        do_reset(1'b0, 1'b0);
        repeat (3) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R7 three leap flag", zf, 0);
        probe(sa, sg);
        check("R7 three leap state", sa, 1);
        do_reset(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R7 two leap flag", zf, 1);
        check("R7 two leap flag gates", zf_g, 1);

        // R1: reset wins over both inputs high, from a nonzero state
        step(1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1; in_a = 1'b1; in_b = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset over inputs", zf, 1);
        check("R1 reset over inputs gates", zf_g, 1);
        @(negedge clk);
        rst = 1'b0; in_a = 1'b0; in_b = 1'b0;
        model = 0;

        // R8: input changes between edges do not move the flag
        @(posedge clk);
        #1;
        in_a = 1'b1;
        #1;
        check("R8 flag stable a", zf, 1);
        in_b = 1'b1;
        #1;
        check("R8 flag stable ab", zf_g, 1);
        in_a = 1'b0;
        in_b = 1'b0;

        // exhaustive sweep: every start state x every input pair
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                do_reset(1'b0, 1'b0);
                for (int i = 0; i < s; i++) step(1'b1, 1'b0);
                step(p[1], p[0]);
                ex = (s + p[1] + p[0]) % 4;
                tag = (p == 0) ? "R2" : ((p == 3) ? "R4" : "R3");
                check({"R5 sweep flag ", tag}, zf, int'(ex == 0));
                check({"R9 sweep flag ", tag}, zf_g, zf);
                probe(sa, sg);
                check({tag, " sweep state behav"}, sa, ex);
                check({tag, " sweep state gates"}, sg, ex);
            end
        end

        // R4: back-to-back leaps
        do_reset(1'b0, 1'b0);
        for (int i = 1; i <= 6; i++) begin
            step(1'b1, 1'b1);
            check("R4 leap run", zf, int'((2 * i) % 4 == 0));
        end

        // R5 / R9: pseudo-random run with leap bursts
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 15);
            if ((i / 64) % 3 == 2) step(1'b1, 1'b1);
            else step(r[0], r[2]);
            check("R5 random vs model", zf, int'(model == 0));
            check("R9 random gates vs behav", zf_g, zf);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule